// File: doc/BRIEF.md
# Configurable Odd Parity Checker and Generator

This block sits between a byte-wide transmit path and a byte-wide receive path. On the transmit side it takes each character, meaning the data byte, the control bits and a parity bit from upstream. It raises a one-cycle error flag when that parity bit does not make the covered bits odd. On the receive side it registers the outgoing data byte and status bits, and in the same cycle it registers a parity bit that gives odd parity over the covered bits. It also drives an output-enable for that parity bit, so the pad can be tri-stated.

A two-bit mode input selects one of three settings: checking and generation off, a narrow coverage setting, or a wide coverage setting. In the narrow setting, the coverage also depends on whether the line encoder and decoder are bypassed. When they are active, only the data byte is covered. When they are bypassed, the two transmit control bits and the two low receive status bits are covered as well. In the wide setting, the data, both control bits and all three status bits are always covered.

Top module: `odd_parity_unit`

## Requirements
- R1: All parity is odd. A transmit character passes when its covered bits plus txPar hold an odd number of ones. The generated rxParOut makes the covered receive bits plus itself hold an odd number of ones.
- R2: With modeSel = 2'b00 (off), txParErr stays 0, rxParOut is 0 and rxParOe is 0.
- R3: modeSel = 2'b11 behaves exactly like 2'b00.
- R4: With modeSel = 2'b01 and codecBypass = 0, the check covers txData[7:0] and txPar only. txCtl has no effect on txParErr.
- R5: With modeSel = 2'b01 and codecBypass = 1, the check covers txData[7:0], txCtl[1:0] and txPar.
- R6: With modeSel = 2'b01 and codecBypass = 0, rxParOut covers rxData[7:0] only. rxStat has no effect on it.
- R7: With modeSel = 2'b01 and codecBypass = 1, rxParOut covers rxData[7:0] and rxStat[1:0]. rxStat[2] has no effect on it.
- R8: With modeSel = 2'b10, the check covers txData, txCtl[1:0] and txPar, and rxParOut covers rxData and rxStat[2:0], whatever the value of codecBypass.
- R9: txParErr is registered. It is 1 for exactly the one cycle after a clock edge at which txValid was 1 and the character failed. It is 0 after any edge at which txValid was 0.
- R10: rxDataQ, rxStatQ, rxValidQ and rxParOut are all captured at the same clock edge. Each one shows the value sampled at that edge, one cycle after the inputs.
- R11: rxParOe is 1 combinationally whenever modeSel is 2'b01 or 2'b10.
- R12: While rstN is low, all registered outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Character clock |
| rstN | input | 1 | Asynchronous active-low reset |
| modeSel | input | 2 | Parity mode: 00 off, 01 narrow, 10 wide, 11 off |
| codecBypass | input | 1 | 1 when the encoder and decoder are bypassed |
| txValid | input | 1 | Transmit character strobe |
| txData | input | 8 | Transmit data byte |
| txCtl | input | 2 | Transmit control bits |
| txPar | input | 1 | Parity bit supplied with the transmit character |
| rxValid | input | 1 | Receive character strobe |
| rxData | input | 8 | Receive data byte |
| rxStat | input | 3 | Receive status bits |
| txParErr | output | 1 | Registered transmit parity error pulse |
| rxValidQ | output | 1 | Registered receive strobe |
| rxDataQ | output | 8 | Registered receive data |
| rxStatQ | output | 3 | Registered receive status |
| rxParOut | output | 1 | Generated odd parity, aligned with rxDataQ |
| rxParOe | output | 1 | Output-enable for rxParOut |

## Verification
Every registered result, both txParErr and the receive outputs with rxParOut, is due one clock edge after its inputs are applied. rxParOe follows modeSel within the same cycle. The bench drives inputs on the falling edge and checks rxParOe shortly after. It then waits for the next rising edge and samples the registered outputs 1 ns later, so each check compares exactly the character that was just driven. The expected values come from reference functions written from the coverage rules.

// File: rtl/parity_pkg.sv
package parity_pkg;

  typedef enum logic [1:0] {
    PM_OFF  = 2'b00,
    PM_MID  = 2'b01,
    PM_HIGH = 2'b10,
    PM_RSVD = 2'b11
  } parMode_e;

  // strobes from control to datapath
  typedef struct packed {
    logic chkEn;       // transmit check active
    logic genEn;       // receive generation active, pad enabled
    logic ctlCover;    // transmit control bits in coverage
    logic statLoCover; // low receive status bits in coverage
    logic statHiCover; // top receive status bit in coverage
  } parStrobe_t;

endpackage

// File: rtl/parity_ctrl.sv
module parity_ctrl
  import parity_pkg::*;
(
  input  logic [1:0] modeSel,
  input  logic       codecBypass,
  output parStrobe_t stb
);

  parMode_e mode;
  assign mode = parMode_e'(modeSel);

  always_comb begin
    stb = '0;
    unique case (mode)
      PM_MID: begin
        stb.chkEn       = 1'b1;
        stb.genEn       = 1'b1;
        stb.ctlCover    = codecBypass;
        stb.statLoCover = codecBypass;
        stb.statHiCover = 1'b0;
      end
      PM_HIGH: begin
        stb.chkEn       = 1'b1;
        stb.genEn       = 1'b1;
        stb.ctlCover    = 1'b1;
        stb.statLoCover = 1'b1;
        stb.statHiCover = 1'b1;
      end
      default: stb = '0;  // off and reserved code
    endcase
  end

endmodule

// File: rtl/parity_path.sv
module parity_path
  import parity_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int CTL_W  = 2,
  parameter int STAT_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  parStrobe_t        stb,
  input  logic              txValid,
  input  logic [DATA_W-1:0] txData,
  input  logic [CTL_W-1:0]  txCtl,
  input  logic              txPar,
  input  logic              rxValid,
  input  logic [DATA_W-1:0] rxData,
  input  logic [STAT_W-1:0] rxStat,
  output logic              txParErr,
  output logic              rxValidQ,
  output logic [DATA_W-1:0] rxDataQ,
  output logic [STAT_W-1:0] rxStatQ,
  output logic              rxParOut,
  output logic              rxParOe
);

  localparam int STAT_LO_W = CTL_W;
  localparam int STAT_HI_W = STAT_W - STAT_LO_W;

  logic [CTL_W-1:0]  ctlMask;
  logic [STAT_W-1:0] statMask;
  logic              txOdd;
  logic              rxGen;

  assign ctlMask  = {CTL_W{stb.ctlCover}};
  assign statMask = {{STAT_HI_W{stb.statHiCover}}, {STAT_LO_W{stb.statLoCover}}};

  assign txOdd = (^txData) ^ (^(txCtl & ctlMask)) ^ txPar;
  assign rxGen = ~((^rxData) ^ (^(rxStat & statMask)));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txParErr <= 1'b0;
      rxValidQ <= 1'b0;
      rxDataQ  <= '0;
      rxStatQ  <= '0;
      rxParOut <= 1'b0;
    end else begin
      txParErr <= txValid & stb.chkEn & ~txOdd;
      rxValidQ <= rxValid;
      rxDataQ  <= rxData;
      rxStatQ  <= rxStat;
      rxParOut <= stb.genEn & rxGen;
    end
  end

  assign rxParOe = stb.genEn;

endmodule

// File: rtl/odd_parity_unit.sv
module odd_parity_unit
  import parity_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int CTL_W  = 2,
  parameter int STAT_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        modeSel,
  input  logic              codecBypass,
  input  logic              txValid,
  input  logic [DATA_W-1:0] txData,
  input  logic [CTL_W-1:0]  txCtl,
  input  logic              txPar,
  input  logic              rxValid,
  input  logic [DATA_W-1:0] rxData,
  input  logic [STAT_W-1:0] rxStat,
  output logic              txParErr,
  output logic              rxValidQ,
  output logic [DATA_W-1:0] rxDataQ,
  output logic [STAT_W-1:0] rxStatQ,
  output logic              rxParOut,
  output logic              rxParOe
);

  parStrobe_t stb;

  parity_ctrl u_ctrl (
    .modeSel     (modeSel),
    .codecBypass (codecBypass),
    .stb         (stb)
  );

  parity_path #(
    .DATA_W (DATA_W),
    .CTL_W  (CTL_W),
    .STAT_W (STAT_W)
  ) u_path (
    .clk      (clk),
    .rstN     (rstN),
    .stb      (stb),
    .txValid  (txValid),
    .txData   (txData),
    .txCtl    (txCtl),
    .txPar    (txPar),
    .rxValid  (rxValid),
    .rxData   (rxData),
    .rxStat   (rxStat),
    .txParErr (txParErr),
    .rxValidQ (rxValidQ),
    .rxDataQ  (rxDataQ),
    .rxStatQ  (rxStatQ),
    .rxParOut (rxParOut),
    .rxParOe  (rxParOe)
  );

endmodule

// File: rtl/odd_parity_unit_chk.sv
module odd_parity_unit_chk #(
  parameter int DATA_W = 8,
  parameter int CTL_W  = 2,
  parameter int STAT_W = 3
) (
  input logic              clk,
  input logic              rstN,
  input logic [1:0]        modeSel,
  input logic              codecBypass,
  input logic              txValid,
  input logic              txParErr,
  input logic [DATA_W-1:0] rxDataQ,
  input logic [STAT_W-1:0] rxStatQ,
  input logic              rxParOut,
  input logic              rxParOe
);

  logic pastOk;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pastOk <= 1'b0;
    else       pastOk <= 1'b1;
  end

  // R9
  err_needs_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pastOk && txParErr) |-> $past(txValid));

  // R2
  off_no_err_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pastOk && txParErr) |-> ($past(modeSel) == 2'b01 || $past(modeSel) == 2'b10));

  // R3
  off_par_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pastOk && ($past(modeSel) == 2'b00 || $past(modeSel) == 2'b11)) |-> !rxParOut);

  // R11
  oe_mode_chk: assert property (@(posedge clk) disable iff (!rstN)
    rxParOe == (modeSel == 2'b01 || modeSel == 2'b10));

  // R8
  wide_gen_odd_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pastOk && $past(modeSel) == 2'b10) |-> (^{rxDataQ, rxStatQ, rxParOut}));

  // R6
  narrow_gen_odd_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pastOk && $past(modeSel) == 2'b01 && !$past(codecBypass)) |-> (^{rxDataQ, rxParOut}));

  // R7
  bypass_gen_odd_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pastOk && $past(modeSel) == 2'b01 && $past(codecBypass))
      |-> (^{rxDataQ, rxStatQ[CTL_W-1:0], rxParOut}));

endmodule

bind odd_parity_unit odd_parity_unit_chk #(
  .DATA_W (DATA_W),
  .CTL_W  (CTL_W),
  .STAT_W (STAT_W)
) u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .modeSel     (modeSel),
  .codecBypass (codecBypass),
  .txValid     (txValid),
  .txParErr    (txParErr),
  .rxDataQ     (rxDataQ),
  .rxStatQ     (rxStatQ),
  .rxParOut    (rxParOut),
  .rxParOe     (rxParOe)
);

// File: tb/odd_parity_unit_tb.sv
`timescale 1ns/1ps
module odd_parity_unit_tb;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [1:0] modeSel = 2'b00;
  logic       codecBypass = 1'b0;
  logic       txValid = 1'b0;
  logic [7:0] txData = '0;
  logic [1:0] txCtl = '0;
  logic       txPar = 1'b0;
  logic       rxValid = 1'b0;
  logic [7:0] rxData = '0;
  logic [2:0] rxStat = '0;
  logic       txParErr, rxValidQ, rxParOut, rxParOe;
  logic [7:0] rxDataQ;
  logic [2:0] rxStatQ;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;  // 125 MHz

  odd_parity_unit u_dut (
    .clk(clk), .rstN(rstN), .modeSel(modeSel), .codecBypass(codecBypass),
    .txValid(txValid), .txData(txData), .txCtl(txCtl), .txPar(txPar),
    .rxValid(rxValid), .rxData(rxData), .rxStat(rxStat),
    .txParErr(txParErr), .rxValidQ(rxValidQ), .rxDataQ(rxDataQ),
    .rxStatQ(rxStatQ), .rxParOut(rxParOut), .rxParOe(rxParOe)
  );

  function automatic bit isOn(input logic [1:0] m);
    return (m == 2'b01) || (m == 2'b10);
  endfunction

  function automatic bit refTxErr(input logic [1:0] m, input bit byp, input bit v,
                                  input logic [7:0] d, input logic [1:0] c, input bit p);
    bit cnt;
    if (!v || !isOn(m)) return 1'b0;
    cnt = (^d) ^ p;
    if (m == 2'b10 || byp) cnt = cnt ^ (^c);
    return !cnt;
  endfunction

  function automatic bit refRxPar(input logic [1:0] m, input bit byp,
                                  input logic [7:0] d, input logic [2:0] s);
    bit cnt;
    if (!isOn(m)) return 1'b0;
    cnt = ^d;
    if (m == 2'b10) cnt = cnt ^ (^s);
    else if (byp)   cnt = cnt ^ (^s[1:0]);
    return !cnt;
  endfunction

  function automatic string tagFor(input logic [1:0] m, input bit byp);
    case (m)
      2'b00:   return "R2";
      2'b11:   return "R3";
      2'b01:   return byp ? "R5/R7" : "R4/R6";
      default: return "R8";
    endcase
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic stim(input logic [1:0] m, input bit byp, input bit v,
                      input logic [7:0] d, input logic [1:0] c, input bit p,
                      input bit rv, input logic [7:0] rd, input logic [2:0] rs);
    string t;
    t = tagFor(m, byp);
    @(negedge clk);
    modeSel = m; codecBypass = byp; txValid = v; txData = d; txCtl = c; txPar = p;
    rxValid = rv; rxData = rd; rxStat = rs;
    #1;
    check({"R11 oe ", t}, rxParOe, isOn(m));
    @(posedge clk);
    #1;
    check({"R1 R9 txParErr ", t}, txParErr, refTxErr(m, byp, v, d, c, p));
    check({"R1 rxParOut ", t}, rxParOut, refRxPar(m, byp, rd, rs));
    check("R10 rxDataQ", rxDataQ, rd);
    check("R10 rxStatQ", rxStatQ, rs);
    check("R10 rxValidQ", rxValidQ, rv);
  endtask

  initial begin
    #(8 * 150000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int unused;
    unused = $urandom(32'h5EED_0042);
    txValid = 1'b1; txData = 8'h00; txPar = 1'b0; rxData = 8'h01;
    modeSel = 2'b10;
    repeat (3) @(posedge clk);
    #1;
    // R12 outputs held at zero in reset
    check("R12 txParErr", txParErr, 1'b0);
    check("R12 rxParOut", rxParOut, 1'b0);
    check("R12 rxDataQ", rxDataQ, 8'h00);
    check("R12 rxValidQ", rxValidQ, 1'b0);
    @(negedge clk); rstN = 1'b1;

    // R2/R3 off modes: bad parity ignored, output disabled
    stim(2'b00, 1'b0, 1'b1, 8'h00, 2'b00, 1'b0, 1'b1, 8'h00, 3'b000);
    stim(2'b11, 1'b1, 1'b1, 8'h00, 2'b11, 1'b0, 1'b1, 8'h03, 3'b111);
    // R4 narrow: txCtl ignored (data odd with p=0, ctl odd)
    stim(2'b01, 1'b0, 1'b1, 8'h01, 2'b01, 1'b0, 1'b1, 8'h01, 3'b011);
    // R4 narrow: data fails
    stim(2'b01, 1'b0, 1'b1, 8'h03, 2'b00, 1'b0, 1'b1, 8'h00, 3'b111);
    // R9 no error without valid
    stim(2'b01, 1'b0, 1'b0, 8'h03, 2'b00, 1'b0, 1'b0, 8'h00, 3'b000);
    // R5 bypass: same ctl now causes error
    stim(2'b01, 1'b1, 1'b1, 8'h01, 2'b01, 1'b0, 1'b1, 8'h01, 3'b100);
    // R7 bypass: rxStat[2] ignored
    stim(2'b01, 1'b1, 1'b1, 8'h01, 2'b00, 1'b0, 1'b1, 8'h00, 3'b100);
    // R8 wide: bypass low and high agree, stat[2] covered
    stim(2'b10, 1'b0, 1'b1, 8'h01, 2'b01, 1'b1, 1'b1, 8'h00, 3'b100);
    stim(2'b10, 1'b1, 1'b1, 8'h01, 2'b01, 1'b0, 1'b1, 8'h00, 3'b100);
    // R9 back-to-back failing characters give back-to-back flags
    stim(2'b10, 1'b0, 1'b1, 8'h00, 2'b00, 1'b0, 1'b0, 8'hFF, 3'b000);
    stim(2'b10, 1'b0, 1'b1, 8'h00, 2'b00, 1'b0, 1'b0, 8'hFF, 3'b000);

    // R1 random mix across all modes
    for (int i = 0; i < 3000; i++) begin
      stim(2'($urandom), 1'($urandom), 1'($urandom), 8'($urandom), 2'($urandom),
           1'($urandom), 1'($urandom), 8'($urandom), 3'($urandom));
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule